// File: doc/BRIEF.md
# Multi-Mode Parallel Port Transfer Controller

This block moves bytes between a host register interface and up to four 8-bit peripheral ports. Each port has its own configuration byte. That byte picks how the host learns that a transfer has finished: a ready flag the host polls, an interrupt request, or a direct data-acknowledge strobe. The same byte can also let the peripheral's busy status line pause a transfer while it is in flight.

A peripheral starts an inbound transfer by strobing its request line while presenting a byte. The controller takes a fixed number of cycles to finish the transfer, and stalls on any cycle where the inhibit gate is enabled and the busy line is high. When the transfer finishes, the byte lands in the port's input data register and the notification chosen by the mode is produced. Any host read or write of the port data register acknowledges the transfer. A host write to that register also sets the port's output byte.

Register groups sit at fixed offsets, with one byte per port inside each group (port p at group base + p):

- 0x00: data register. Reads return the captured input byte. Writes set the output byte.
- 0x08: transfer control register. Bit 0 is the ready flag.
- 0x10: status register. Bit 0 is 1 while a transfer is in progress. Bit 1 is the interrupt-pending flag.
- 0x18: configuration register.

Top module: `ppt_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every register. After reset, every configuration reads 0x00 (polled-flag mode, inhibit off), all flags, irq and dtack are 0, and every output byte is 0x00.
- R2: The configuration byte of port p sits at 0x18+p. Its layout is bits 1:0 mode, bit 4 inhibit enable and bits 7:5 handshake type. Bits 3:2 always read 0 and are ignored on write. The handshake type appears on `hs_type` for that port, and the register keeps its value when it is not written.
- R3: A request strobe accepted on a clock edge while the port is idle completes XFER_CYCLES edges later, when nothing stalls it. The byte captured with the request is then readable at 0x00+p.
- R4: In mode 00 (polled flag), and in the reserved mode 11, which behaves the same way, completion sets the ready bit (bit 0 at 0x08+p). It raises neither irq nor dtack.
- R5: In mode 01 (interrupt), completion sets the pending bit (bit 1 at 0x10+p) and raises `irq[p]`. The ready bit stays 0, and irq is only ever high while the port is in mode 01.
- R6: In mode 10 (fast), completion drives `dtack[p]` high for exactly one cycle. Ready, pending and irq stay 0.
- R7: Any host read or write of the data register at 0x00+p clears that port's ready bit, pending bit and irq.
- R8: A configuration write that changes the mode field drops `irq[p]` on that same edge. The pending bit is left as it is.
- R9: With inhibit enabled, every edge on which the busy line is high during a transfer holds the transfer. The transfer resumes when the line goes low, so completion is delayed by exactly the number of busy edges.
- R10: With inhibit disabled, the busy line is ignored and completion timing is unaffected.
- R11: A request strobe that arrives while a transfer is in progress is ignored. The captured byte is not replaced.
- R12: A host write to 0x00+p sets the output byte `port_out` of port p on the next edge.
- R13: Status bit 0 at 0x10+p reads 1 from the edge that accepts a request until the edge that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | AW | Host register byte offset |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, combinational from the address |
| per_req | input | NPORT | Per-port peripheral request strobe |
| per_data | input | NPORT*DW | Per-port peripheral input byte |
| per_sts_busy | input | NPORT | Per-port peripheral status, 1 = busy |
| port_out | output | NPORT*DW | Per-port output byte |
| hs_type | output | NPORT*3 | Per-port handshake type code |
| irq | output | NPORT | Per-port interrupt request |
| dtack | output | NPORT | Per-port one-cycle data acknowledge |

## Verification
On every cycle, the embedded assertions check these properties:
- a stalled transfer keeps its remaining count;
- an unstalled transfer with inhibit off counts down by one;
- dtack never lasts two cycles;
- irq is never high outside interrupt mode;
- a data-register access clears the flags;
- an unwritten configuration byte stays unchanged.

Only the bench's sweep can show the other behaviours:
- the absolute completion cycle, including the exact delay added by busy edges;
- which flag each of the four modes picks;
- that the reserved bits are masked;
- that a second request is dropped;
- that a mode change withdraws the interrupt while the pending bit stays set.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

    typedef enum logic [1:0] {
        MODE_FLAG = 2'b00,
        MODE_INTR = 2'b01,
        MODE_FAST = 2'b10,
        MODE_RSVD = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic [2:0] ht;
        logic       ei;
        xfer_mode_e mode;
    } port_cfg_t;

    localparam logic [1:0] GRP_DATA = 2'd0;
    localparam logic [1:0] GRP_CTRL = 2'd1;
    localparam logic [1:0] GRP_STAT = 2'd2;
    localparam logic [1:0] GRP_CFG  = 2'd3;

    function automatic logic [7:0] cfg_to_byte(input port_cfg_t c);
        return {c.ht, c.ei, 2'b00, c.mode};
    endfunction

    function automatic port_cfg_t byte_to_cfg(input logic [7:0] b);
        port_cfg_t c;
        c.ht   = b[7:5];
        c.ei   = b[4];
        c.mode = xfer_mode_e'(b[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/ppt_cfg_reg.sv
module ppt_cfg_reg
    import ppt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output port_cfg_t  cfg_o,
    output logic       mode_chg_o
);

    typedef struct packed {
        port_cfg_t cfg;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    port_cfg_t wr_cfg;

    always_comb begin
        st_d       = st_q;
        wr_cfg     = byte_to_cfg(wr_data);
        mode_chg_o = 1'b0;
        if (wr_en) begin
            st_d.cfg   = wr_cfg;
            mode_chg_o = (wr_cfg.mode != st_q.cfg.mode);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;

    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st_q.cfg)); // R2

endmodule

// File: rtl/ppt_xfer.sv
module ppt_xfer
    import ppt_pkg::*;
#(
    parameter int DW          = 8,
    parameter int XFER_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  port_cfg_t     cfg_i,
    input  logic          mode_chg_i,
    input  logic          host_acc_i,
    input  logic          host_wr_i,
    input  logic [DW-1:0] host_wdata_i,
    input  logic          req_i,
    input  logic [DW-1:0] pdata_i,
    input  logic          busy_i,
    output logic [DW-1:0] din_o,
    output logic [DW-1:0] dout_o,
    output logic          ready_o,
    output logic          pend_o,
    output logic          irq_o,
    output logic          ack_o,
    output logic          active_o
);

    localparam int CW = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(XFER_CYCLES - 1);

    typedef struct packed {
        logic          running;
        logic [CW-1:0] cnt;
        logic [DW-1:0] cap;
        logic [DW-1:0] din;
        logic [DW-1:0] dout;
        logic          ready;
        logic          pend;
        logic          irq;
        logic          ack;
    } xfer_st_t;

    xfer_st_t st_d, st_q;
    logic     done;
    logic     stall;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        done     = 1'b0;
        stall    = cfg_i.ei && busy_i;

        if (!st_q.running) begin
            if (req_i) begin
                st_d.running = 1'b1;
                st_d.cnt     = CNT_INIT;
                st_d.cap     = pdata_i;
            end
        end else if (!stall) begin
            if (st_q.cnt == '0) begin
                st_d.running = 1'b0;
                done         = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (host_acc_i) begin
            st_d.ready = 1'b0;
            st_d.pend  = 1'b0;
            st_d.irq   = 1'b0;
        end

        if (host_wr_i) st_d.dout = host_wdata_i;

        if (done) begin
            st_d.din = st_q.cap;
            unique case (cfg_i.mode)
                MODE_INTR: begin
                    st_d.pend = 1'b1;
                    st_d.irq  = 1'b1;
                end
                MODE_FAST: st_d.ack   = 1'b1;
                default:   st_d.ready = 1'b1;
            endcase
        end

        if (mode_chg_i) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign din_o    = st_q.din;
    assign dout_o   = st_q.dout;
    assign ready_o  = st_q.ready;
    assign pend_o   = st_q.pend;
    assign irq_o    = st_q.irq;
    assign ack_o    = st_q.ack;
    assign active_o = st_q.running;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q.running && cfg_i.ei && busy_i) |=>
            (st_q.running && st_q.cnt == $past(st_q.cnt))); // R9

    AST_NO_GATE_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (st_q.running && !cfg_i.ei && st_q.cnt != '0) |=>
            (st_q.running && st_q.cnt == $past(st_q.cnt) - 1'b1)); // R10

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o); // R6

    AST_IRQ_MODE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (cfg_i.mode == MODE_INTR)); // R5

    AST_ACC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (host_acc_i && !done) |=> (!ready_o && !irq_o && !pend_o)); // R7

endmodule

// File: rtl/ppt_host_dec.sv
module ppt_host_dec
    import ppt_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 8,
    parameter int AW    = 5
) (
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [AW-1:0]       addr,
    input  logic [NPORT*DW-1:0] din_flat,
    input  logic [NPORT*8-1:0]  cfg_flat,
    input  logic [NPORT-1:0]    ready,
    input  logic [NPORT-1:0]    pend,
    input  logic [NPORT-1:0]    active,
    output logic [NPORT-1:0]    cfg_we,
    output logic [NPORT-1:0]    data_acc,
    output logic [NPORT-1:0]    data_we,
    output logic [DW-1:0]       rdata
);

    logic [1:0] grp;
    logic [2:0] idx;
    logic       hit;

    assign grp = addr[4:3];
    assign idx = addr[2:0];
    assign hit = (32'(idx) < NPORT);

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_dec
            logic sel;
            assign sel         = hit && (idx == 3'(p));
            assign cfg_we[p]   = wr_en && sel && (grp == GRP_CFG);
            assign data_we[p]  = wr_en && sel && (grp == GRP_DATA);
            assign data_acc[p] = (wr_en || rd_en) && sel && (grp == GRP_DATA);
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (rd_en && hit) begin
            for (int p = 0; p < NPORT; p++) begin
                if (idx == 3'(p)) begin
                    unique case (grp)
                        GRP_DATA: rdata = din_flat[p*DW +: DW];
                        GRP_CTRL: rdata = DW'(ready[p]);
                        GRP_STAT: rdata = DW'({pend[p], active[p]});
                        default:  rdata = DW'(cfg_flat[p*8 +: 8]);
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/ppt_ctrl.sv
module ppt_ctrl
    import ppt_pkg::*;
#(
    parameter int NPORT       = 4,
    parameter int DW          = 8,
    parameter int AW          = 5,
    parameter int XFER_CYCLES = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr_en,
    input  logic                host_rd_en,
    input  logic [AW-1:0]       host_addr,
    input  logic [DW-1:0]       host_wdata,
    output logic [DW-1:0]       host_rdata,
    input  logic [NPORT-1:0]    per_req,
    input  logic [NPORT*DW-1:0] per_data,
    input  logic [NPORT-1:0]    per_sts_busy,
    output logic [NPORT*DW-1:0] port_out,
    output logic [NPORT*3-1:0]  hs_type,
    output logic [NPORT-1:0]    irq,
    output logic [NPORT-1:0]    dtack
);

    logic [NPORT-1:0]    cfg_we, data_acc, data_we;
    logic [NPORT-1:0]    ready, pend, active;
    logic [NPORT*DW-1:0] din_flat;
    logic [NPORT*8-1:0]  cfg_flat;

    ppt_host_dec #(.NPORT(NPORT), .DW(DW), .AW(AW)) u_dec (
        .wr_en    (host_wr_en),
        .rd_en    (host_rd_en),
        .addr     (host_addr),
        .din_flat (din_flat),
        .cfg_flat (cfg_flat),
        .ready    (ready),
        .pend     (pend),
        .active   (active),
        .cfg_we   (cfg_we),
        .data_acc (data_acc),
        .data_we  (data_we),
        .rdata    (host_rdata)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            port_cfg_t cfg;
            logic      mode_chg;

            ppt_cfg_reg u_cfg (
                .clk        (clk),
                .rst        (rst),
                .wr_en      (cfg_we[p]),
                .wr_data    (host_wdata[7:0]),
                .cfg_o      (cfg),
                .mode_chg_o (mode_chg)
            );

            assign cfg_flat[p*8 +: 8] = cfg_to_byte(cfg);
            assign hs_type[p*3 +: 3]  = cfg.ht;

            ppt_xfer #(.DW(DW), .XFER_CYCLES(XFER_CYCLES)) u_xfer (
                .clk          (clk),
                .rst          (rst),
                .cfg_i        (cfg),
                .mode_chg_i   (mode_chg),
                .host_acc_i   (data_acc[p]),
                .host_wr_i    (data_we[p]),
                .host_wdata_i (host_wdata),
                .req_i        (per_req[p]),
                .pdata_i      (per_data[p*DW +: DW]),
                .busy_i       (per_sts_busy[p]),
                .din_o        (din_flat[p*DW +: DW]),
                .dout_o       (port_out[p*DW +: DW]),
                .ready_o      (ready[p]),
                .pend_o       (pend[p]),
                .irq_o        (irq[p]),
                .ack_o        (dtack[p]),
                .active_o     (active[p])
            );
        end
    endgenerate

    AST_FAST_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (dtack != '0) |-> ((irq & dtack) == '0)); // R6

endmodule

// File: tb/ppt_ctrl_tb.sv
module ppt_ctrl_tb;

    localparam int NPORT = 4;
    localparam int DW    = 8;
    localparam int AW    = 5;
    localparam int XC    = 3;

    logic                clk = 1'b0;
    logic                rst;
    logic                host_wr_en, host_rd_en;
    logic [AW-1:0]       host_addr;
    logic [DW-1:0]       host_wdata;
    logic [DW-1:0]       host_rdata;
    logic [NPORT-1:0]    per_req, per_sts_busy;
    logic [NPORT*DW-1:0] per_data;
    logic [NPORT*DW-1:0] port_out;
    logic [NPORT*3-1:0]  hs_type;
    logic [NPORT-1:0]    irq, dtack;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] rv;

    always #10 clk = ~clk;

    ppt_ctrl #(.NPORT(NPORT), .DW(DW), .AW(AW), .XFER_CYCLES(XC)) u_dut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .per_req(per_req), .per_data(per_data), .per_sts_busy(per_sts_busy),
        .port_out(port_out), .hs_type(hs_type), .irq(irq), .dtack(dtack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        host_addr = a; host_wdata = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        host_addr = a; host_rd_en = 1'b1;
        #2 d = host_rdata;
        @(negedge clk);
        host_rd_en = 1'b0;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; host_wr_en = 0; host_rd_en = 0; host_addr = '0; host_wdata = '0;
        per_req = '0; per_sts_busy = '0; per_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 dtack", dtack, 0);
        chk("R1 port_out", port_out, 0);
        for (int p = 0; p < NPORT; p++) begin
            rd(AW'(8'h18 + p), rv); chk("R1 cfg", rv, 0);
            rd(AW'(8'h08 + p), rv); chk("R1 ready", rv, 0);
            rd(AW'(8'h10 + p), rv); chk("R1 status", rv, 0);
        end

        for (int p = 0; p < NPORT; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int ei = 0; ei < 2; ei++) begin
                    for (int sb = 0; sb < 2; sb++) begin
                        logic [2:0] ht;
                        logic [7:0] cfgw, dat;
                        int s, seff;
                        ht   = 3'((p * 3 + m + ei) % 8);
                        cfgw = {ht, 1'(ei), 2'b11, 2'(m)};
                        dat  = 8'((p * 64 + m * 16 + ei * 4 + sb * 2 + 1) * 7);
                        s    = sb ? 2 : 0;
                        seff = ei ? s : 0;
                        // R2 config masking and handshake type output
                        wr(AW'(8'h18 + p), cfgw);
                        rd(AW'(8'h18 + p), rv);
                        chk("R2 cfg readback", rv, {ht, 1'(ei), 2'b00, 2'(m)});
                        chk("R2 hs_type", hs_type[p*3 +: 3], ht);
                        // start transfer (negedge N0)
                        per_data[p*DW +: DW] = dat;
                        per_req[p] = 1'b1;
                        @(negedge clk);
                        per_req[p] = 1'b0;
                        per_sts_busy[p] = (s != 0);
                        // R11 second request during transfer is dropped
                        per_data[p*DW +: DW] = ~dat;
                        per_req[p] = 1'b1;
                        @(negedge clk);
                        per_req[p] = 1'b0;
                        if (s > 1) @(negedge clk);
                        per_sts_busy[p] = 1'b0;
                        // now at N(1+s) when s>0, else N2; wait to N(3+seff)
                        repeat (3 + seff - ((s > 1) ? 3 : 2)) @(negedge clk);
                        chk("R9/R10 not yet done irq", irq[p], 0);
                        chk("R9/R10 not yet done dtack", dtack[p], 0);
                        rd(AW'(8'h10 + p), rv);          // R13 active before completion
                        chk("R13 active", rv[0], 1);
                        // now at N(4+seff): completion visible
                        chk("R3/R5 irq", irq[p], (m == 1));
                        chk("R6 dtack", dtack[p], (m == 2));
                        rd(AW'(8'h08 + p), rv);
                        chk("R4 ready", rv, ((m == 0) || (m == 3)) ? 1 : 0);
                        chk("R6 dtack one cycle", dtack[p], 0);
                        rd(AW'(8'h10 + p), rv);
                        chk("R5/R13 status", rv, (m == 1) ? 2 : 0);
                        if (m == 1 && p[0]) begin
                            // R8 mode change drops irq, keeps pending
                            wr(AW'(8'h18 + p), {ht, 1'(ei), 2'b00, 2'b00});
                            chk("R8 irq dropped", irq[p], 0);
                            rd(AW'(8'h10 + p), rv);
                            chk("R8 pend kept", rv, 2);
                        end
                        rd(AW'(8'h00 + p), rv);
                        chk("R3/R11 data", rv, dat);
                        chk("R7 irq cleared", irq[p], 0);
                        rd(AW'(8'h08 + p), rv);
                        chk("R7 ready cleared", rv, 0);
                        rd(AW'(8'h10 + p), rv);
                        chk("R7 pend cleared", rv, 0);
                        // R12 output byte
                        wr(AW'(8'h00 + p), dat ^ 8'h5A);
                        chk("R12 port_out", port_out[p*DW +: DW], dat ^ 8'h5A);
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule